// File: doc/BRIEF.md
# Digital Slope-Adaptive Delta Codec

This block is a fully digital delta modulator whose step size adapts continuously to the signal slope. One datapath serves as both encoder and decoder. In encode mode, on each bit tick, it compares a signed PCM sample with its own running estimate and emits one bit. In decode mode it takes a serial bit stream and rebuilds the same estimate from it. Either way, the chosen bit goes through the same three stages: a short window of recent bits, a coincidence detector that fires when the window is uniform, and a syllabic level filter that drives the step size. The step then feeds a leaky, saturating integrator.

The block runs from a fast system clock. A one-cycle `bit_tick` strobe marks each bit period, and the PCM sample is captured on that strobe. The coincidence output is high for exactly one system clock per qualifying bit. A caller can count those pulses against ticks over a window to measure the companding ratio. Tying `bit_out` back into `data_in` in decode mode forms a toggle, which produces a forced idle pattern.

Top module: `cvsd_codec`

## Requirements
- R1: While reset is applied and immediately after it, `bit_out`=0, `coinc`=0 and `estimate`=0.
- R2: In decode mode (`encode`=0), the bit registered on a tick is the inverse of `data_in`. No output changes in cycles without a tick.
- R3: In encode mode (`encode`=1), the registered bit is 1 when signed `pcm_in` < `estimate`, and 0 otherwise (an equal input gives 0).
- R4: `coinc` is high for exactly the one clock after a tick if the newest HIST bits, including the new one, are all 1 or all 0. It is low in every other cycle.
- R5: On each tick, the syllabic level L (LW bits, max M=2^LW-1) becomes L+((M-L)>>ATT) when coincidence holds. Otherwise it becomes L-max(L>>DEC,1), with a floor of 0.
- R6: The step used on a tick is MIN_STEP+((L*GAIN)>>GSH), computed from the level held before that tick and clamped to 2^(W-1)-1. After reset the first step is MIN_STEP.
- R7: On a tick, the estimate E becomes E-(E>>>LEAK) plus the step when the bit is 0, or minus the step when the bit is 1.
- R8: In decode mode with `data_in` driven from `bit_out`, the output alternates 1,0,1,... and `coinc` never rises.
- R9: In encode mode with a constant zero input, the step decays to MIN_STEP. The bits then alternate and |`estimate`| stays within 2*MIN_STEP.
- R10: The estimate saturates at 2^(W-1)-1 and -2^(W-1) and never wraps.
- R11: The window length is the HIST parameter (3 or 4). The history resets to a mixed pattern, so a 3-bit build flags a run one bit sooner than a 4-bit build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle strobe marking a bit period |
| encode | input | 1 | 1: bit comes from the comparison; 0: bit comes from `data_in` |
| pcm_in | input | W | Signed PCM sample, captured on a tick |
| data_in | input | 1 | Serial data, inverting relative to `bit_out` |
| bit_out | output | 1 | Serial bit produced on the last tick |
| coinc | output | 1 | One-cycle coincidence pulse |
| estimate | output | W | Signed reconstructed sample |

## Verification
The inline properties check the per-cycle rules on every cycle:
- outputs hold between ticks;
- the serial-inversion and comparison rules for the registered bit;
- the direction of the level update under coincidence and decay;
- the step floor;
- an estimate that never wraps across zero.

Only the bench scenarios can show the exact arithmetic trajectory, which is compared tick by tick against an independent model. The same holds for the convergence to an idle triangle, the toggle loopback, and the different coincidence timing of 3-bit and 4-bit windows.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
  typedef enum logic {
    SRC_SERIAL  = 1'b0,
    SRC_COMPARE = 1'b1
  } bit_src_e;
endpackage

// File: rtl/cvsd_history.sv
module cvsd_history #(
  parameter int unsigned HIST = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic new_bit,
  output logic uni_next,
  output logic coinc_q
);
  localparam int unsigned KEEP = HIST - 1;
  localparam logic [HIST-1:0] ALL_ONE = '1;

  logic [KEEP-1:0] hist_q, hist_d, hist_rst;
  logic [HIST-1:0] window;

  for (genvar g = 0; g < KEEP; g++) begin : g_rst_pat
    assign hist_rst[g] = ((g % 2) == 1);
  end

  always_comb begin
    window   = {hist_q, new_bit};
    uni_next = (window == '0) || (window == ALL_ONE);
    hist_d   = tick ? window[KEEP-1:0] : hist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= hist_rst;
      coinc_q <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      coinc_q <= tick & uni_next;
    end
  end

  p_coinc_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coinc_q |-> $past(tick));
endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic #(
  parameter int unsigned W        = 12,
  parameter int unsigned LW       = 10,
  parameter int unsigned ATT      = 2,
  parameter int unsigned DEC      = 5,
  parameter int unsigned MIN_STEP = 4,
  parameter int unsigned GAIN     = 1,
  parameter int unsigned GSH      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          coin_in,
  output logic [W-2:0]  step
);
  localparam int unsigned PW       = LW + 17;
  localparam int unsigned STEP_MAX = (2 ** (W - 1)) - 1;

  logic [LW-1:0] lvl_q, lvl_d, gap, dec_amt;
  logic [PW-1:0] scaled, raw;

  always_comb begin
    gap     = ~lvl_q;
    dec_amt = lvl_q >> DEC;
    if (dec_amt == '0 && lvl_q != '0) dec_amt = {{(LW-1){1'b0}}, 1'b1};
    lvl_d = lvl_q;
    if (tick) begin
      if (coin_in) lvl_d = lvl_q + (gap >> ATT);
      else         lvl_d = lvl_q - dec_amt;
    end
  end

  always_comb begin
    scaled = (PW'(lvl_q) * PW'(GAIN)) >> GSH;
    raw    = scaled + PW'(MIN_STEP);
    if (raw > PW'(STEP_MAX)) step = (W-1)'(STEP_MAX);
    else                     step = raw[W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  p_attack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && coin_in) |-> lvl_q >= $past(lvl_q));
  p_decay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !coin_in) |-> lvl_q <= $past(lvl_q));
  p_step_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step >= (W-1)'(MIN_STEP));
endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator #(
  parameter int unsigned W    = 12,
  parameter int unsigned LEAK = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rise,
  input  logic [W-2:0]        step,
  output logic signed [W-1:0] est_q
);
  localparam int unsigned EW = W + 2;
  localparam logic signed [EW-1:0] HI_E = EW'((2 ** (W - 1)) - 1);
  localparam logic signed [EW-1:0] LO_E = -EW'(2 ** (W - 1));
  localparam logic signed [W-1:0]  HI_W = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  LO_W = {1'b1, {(W-1){1'b0}}};

  logic signed [EW-1:0] ext_est, leaked, step_ext, summed;
  logic signed [W-1:0]  est_d;

  always_comb begin
    ext_est  = $signed({{2{est_q[W-1]}}, est_q});
    leaked   = ext_est - (ext_est >>> LEAK);
    step_ext = $signed({3'b000, step});
    summed   = rise ? (leaked + step_ext) : (leaked - step_ext);
    est_d    = est_q;
    if (tick) begin
      if (summed > HI_E)      est_d = HI_W;
      else if (summed < LO_E) est_d = LO_W;
      else                    est_d = summed[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) est_q <= '0;
    else        est_q <= est_d;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(est_q));
  p_no_wrap_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick && rise) && $past(est_q) >= 0) |-> est_q >= 0);
  p_no_wrap_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick && !rise) && $past(est_q) < 0) |-> est_q < 0);
endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec
  import cvsd_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter int unsigned HIST     = 3,
  parameter int unsigned LW       = 10,
  parameter int unsigned ATT      = 2,
  parameter int unsigned DEC      = 5,
  parameter int unsigned MIN_STEP = 4,
  parameter int unsigned GAIN     = 1,
  parameter int unsigned GSH      = 2,
  parameter int unsigned LEAK     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                encode,
  input  logic signed [W-1:0] pcm_in,
  input  logic                data_in,
  output logic                bit_out,
  output logic                coinc,
  output logic signed [W-1:0] estimate
);
  logic [1:0]   rs_q;
  logic         rst_int;
  bit_src_e     src;
  logic         cmp_bit, new_bit, uni_next;
  logic [W-2:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int = rs_q[1];

  always_comb begin
    src     = encode ? SRC_COMPARE : SRC_SERIAL;
    cmp_bit = (pcm_in < estimate);
    new_bit = (src == SRC_COMPARE) ? cmp_bit : ~data_in;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)      bit_out <= 1'b0;
    else if (bit_tick) bit_out <= new_bit;
  end

  cvsd_history #(.HIST(HIST)) u_hist (
    .clk(clk), .rst_n(rst_int), .tick(bit_tick), .new_bit(new_bit),
    .uni_next(uni_next), .coinc_q(coinc)
  );

  cvsd_syllabic #(
    .W(W), .LW(LW), .ATT(ATT), .DEC(DEC),
    .MIN_STEP(MIN_STEP), .GAIN(GAIN), .GSH(GSH)
  ) u_syl (
    .clk(clk), .rst_n(rst_int), .tick(bit_tick), .coin_in(uni_next), .step(step)
  );

  cvsd_integrator #(.W(W), .LEAK(LEAK)) u_int (
    .clk(clk), .rst_n(rst_int), .tick(bit_tick), .rise(~new_bit),
    .step(step), .est_q(estimate)
  );

  p_serial_inv_r2: assert property (@(posedge clk) disable iff (!rst_int)
    ($past(bit_tick) && !$past(encode)) |-> bit_out == !$past(data_in));
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_int)
    !$past(bit_tick) |-> $stable(bit_out));
  p_compare_r3: assert property (@(posedge clk) disable iff (!rst_int)
    ($past(bit_tick) && $past(encode)) |-> bit_out == ($past(pcm_in) < $past(estimate)));
endmodule

// File: tb/cvsd_codec_bench.sv
module cvsd_codec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MINS = 4, GAINV = 1, GSHV = 2, ATTV = 2, DECV = 5, LEAKV = 6;
  localparam int LMAX = 1023, EHI = 2047, ELO = -2048;

  logic clk = 0, rst_n = 0, bit_tick = 0, encode = 0, data_in = 0;
  logic signed [11:0] pcm_in = '0;
  logic b3, c3, b4, c4;
  logic signed [11:0] e3, e4;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvsd_codec #(.HIST(3)) u_cvsd_codec (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .encode(encode), .pcm_in(pcm_in),
    .data_in(data_in), .bit_out(b3), .coinc(c3), .estimate(e3));
  cvsd_codec #(.HIST(4)) u_cvsd_codec_h4 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .encode(encode), .pcm_in(pcm_in),
    .data_in(data_in), .bit_out(b4), .coinc(c4), .estimate(e4));

  typedef struct {
    int bv[2]; int cv[2]; int ev[2]; string tag;
  } exp_t;
  exp_t q[$];

  int n_cmp = 0, n_bad = 0;
  int m_est[2], m_lvl[2], m_hist[2], m_bit[2];
  int hl[2] = '{3, 4};
  bit monitor_on = 0, tick_seen = 0, done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_est[i] = 0; m_lvl[i] = 0; m_hist[i] = 2; m_bit[i] = 0;
    end
  endtask

  task automatic drive(string tag, bit enc, int pcm, bit din);
    exp_t it;
    @(negedge clk);
    encode = enc; pcm_in = pcm[11:0]; data_in = din; bit_tick = 1;
    for (int i = 0; i < 2; i++) begin
      int nb, stp, e, w, full, un, d;
      nb  = enc ? ((pcm < m_est[i]) ? 1 : 0) : (din ? 0 : 1);
      stp = MINS + ((m_lvl[i] * GAINV) >> GSHV);
      if (stp > EHI) stp = EHI;
      e = m_est[i] - (m_est[i] >>> LEAKV) + (nb ? -stp : stp);
      if (e > EHI) e = EHI;
      if (e < ELO) e = ELO;
      full = (1 << hl[i]) - 1;
      w  = ((m_hist[i] << 1) | nb) & full;
      un = (w == 0 || w == full) ? 1 : 0;
      m_hist[i] = w & ((1 << (hl[i] - 1)) - 1);
      if (un) m_lvl[i] = m_lvl[i] + ((LMAX - m_lvl[i]) >> ATTV);
      else begin
        d = m_lvl[i] >> DECV;
        if (d == 0 && m_lvl[i] != 0) d = 1;
        m_lvl[i] = m_lvl[i] - d;
      end
      m_est[i] = e; m_bit[i] = nb;
      it.bv[i] = nb; it.cv[i] = un; it.ev[i] = e;
    end
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    bit_tick = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) tick_seen <= bit_tick;

  // Monitor: pops expected items as results appear; R4 checks quiet cycles.
  always @(negedge clk) begin
    if (monitor_on) begin
      if (tick_seen) begin
        if (q.size() == 0) chk("R4", "unexpected tick result", 1, 0);
        else begin
          exp_t it;
          it = q.pop_front();
          chk(it.tag, "bit h3", int'(b3), it.bv[0]);
          chk(it.tag, "coinc h3", int'(c3), it.cv[0]);
          chk(it.tag, "est h3", int'(e3), it.ev[0]);
          chk(it.tag, "bit h4", int'(b4), it.bv[1]);
          chk(it.tag, "coinc h4", int'(c4), it.cv[1]);
          chk(it.tag, "est h4", int'(e4), it.ev[1]);
        end
      end else begin
        chk("R4", "coinc quiet h3", int'(c3), 0);
        chk("R4", "coinc quiet h4", int'(c4), 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int prev;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", "bit in reset", int'(b3), 0);
    chk("R1", "est in reset", int'(e3), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1", "bit after reset", int'(b3), 0);
    chk("R1", "coinc after reset", int'(c3), 0);
    chk("R1", "est after reset", int'(e3), 0);
    monitor_on = 1;

    // R6: first step equals MIN_STEP
    drive("R6", 0, 0, 1);
    chk("R6", "first step", int'(e3), MINS);
    // R2 / R7 decode mixed pattern
    for (int k = 0; k < 24; k++) drive((k < 12) ? "R2" : "R7", 0, 0, (k * 5 + k / 3) % 3 == 0);
    // R11: mixed, then a run of three equal bits (3-bit flags, 4-bit not yet)
    drive("R11", 0, 0, 1); drive("R11", 0, 0, 0);
    drive("R11", 0, 0, 1); drive("R11", 0, 0, 1); drive("R11", 0, 0, 1);
    chk("R11", "h3 flags run of 3", int'(m_bit[0] == 0 && q.size() == 0), 1);
    drive("R11", 0, 0, 1);
    // R5 attack run, then decay
    for (int k = 0; k < 8; k++) drive("R5", 0, 0, 0);
    for (int k = 0; k < 8; k++) drive("R5", 0, 0, k % 2);
    // R10 saturation high then low
    for (int k = 0; k < 60; k++) drive("R10", 0, 0, 1);
    chk("R10", "sat high", int'(e3), EHI);
    for (int k = 0; k < 60; k++) drive("R10", 0, 0, 0);
    chk("R10", "sat low", int'(e3), ELO);
    // R8 toggle loopback
    prev = int'(b3);
    for (int k = 0; k < 40; k++) begin
      drive("R8", 0, 0, m_bit[0]);
      if (k > 0) chk("R8", "alternation", int'(b3), 1 - prev);
      prev = int'(b3);
    end
    // R3 encode triangle input
    for (int k = 0; k < 128; k++) begin
      int ph, v;
      ph = k % 64;
      v  = (ph < 32) ? (ph * 75 - 1200) : (1200 - (ph - 32) * 75);
      drive("R3", 1, v, 0);
    end
    drive("R3", 1, int'(e3), 0);
    chk("R3", "equal input gives 0", int'(b3), 0);
    // R9 idle encode
    for (int k = 0; k < 300; k++) drive("R9", 1, 0, 0);
    prev = int'(b3);
    for (int k = 0; k < 20; k++) begin
      drive("R9", 1, 0, 0);
      chk("R9", "idle alternation", int'(b3), 1 - prev);
      chk("R9", "idle bound", int'(e3 <= 2*MINS && e3 >= -2*MINS), 1);
      prev = int'(b3);
    end
    repeat (3) @(negedge clk);
    chk("R4", "queue drained", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule